// File: doc/BRIEF.md
# Write Strobe Guard

This block sits between the raw memory control pins and the write sequencer of a byte-wide nonvolatile memory. It decides whether a write strobe may reach the sequencer. It receives a digital supply-good flag, the active-low chip-select, write-strobe and output-enable pins, and a clock. All four asynchronous inputs pass through two-flop synchronizers.

The guard holds writes off in three situations:

- The supply flag is low.
- The supply has been good for less than a fixed lockout time.
- Output-enable is low.

It also filters the two strobes. A low pulse on chip-select or write-strobe only passes once it has stayed low for a minimum number of clock cycles, so narrow glitches never start a write. The cost is a fixed added latency on the falling edge of each strobe. The rising edge is passed straight through.

The outputs are the qualified strobes, the synchronized output-enable, and a flag that is high when a write is currently allowed. The lockout length and the minimum pulse width are parameters in clock cycles.

Top module: `wguard_top`

## Requirements
- R1: While the synchronized supply flag is low, ce_no and we_no are 1 and wr_allow_o is 0, whatever the strobes do.
- R2: Suppose supply_ok_i rises just before clock edge a, and chip-select and write-strobe stay low with output-enable high. Then wr_allow_o first becomes 1 after edge a+1+LOCK_CYC, which is LOCK_CYC+2 edges after the input change.
- R3: While the synchronized output-enable is low (oe_ni = 0), we_no is 1 and wr_allow_o is 0. oe_no follows oe_ni with a two-edge delay.
- R4: A low pulse on ce_ni or we_ni lasting fewer than MIN_LOW_CYC clock cycles never drives the matching qualified output low.
- R5: A low pulse lasting N >= MIN_LOW_CYC cycles, with the lockout expired, drives the qualified output low MIN_LOW_CYC+1 edges after the input falls. It stays low for N-MIN_LOW_CYC+1 cycles.
- R6: When a qualified strobe is low and its raw input rises, the qualified output returns to 1 two edges later, with no filter delay.
- R7: A fall of the supply flag drops any strobe in progress and restarts the lockout. After the supply returns, a held-low strobe pair is re-allowed only after a further LOCK_CYC+2 edges.
- R8: wr_allow_o is 1 exactly when ce_no and we_no are both 0.
- R9: During reset and at its release, ce_no, we_no and oe_no are 1 and wr_allow_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply-good flag, asynchronous |
| ce_ni | input | 1 | Raw chip-select, active low |
| we_ni | input | 1 | Raw write strobe, active low |
| oe_ni | input | 1 | Raw output-enable, active low |
| ce_no | output | 1 | Qualified chip-select, active low |
| we_no | output | 1 | Qualified write strobe, active low |
| oe_no | output | 1 | Synchronized output-enable, active low |
| wr_allow_o | output | 1 | High while a write may proceed |

## Verification
The interesting overlap is the supply flag dropping, or the lockout ending, in the same cycle that a filtered strobe reaches its minimum width or releases. The bench provokes this in two ways. Directed runs cut the supply in the middle of a held strobe pair. A long random phase toggles supply, strobes and output-enable independently at different rates. Every cycle is judged against a bench model of the synchronizer delay, the lockout count and the per-strobe low-run counts.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef struct packed {
    logic sup_ok;
    logic ce_n;
    logic we_n;
    logic oe_n;
  } wg_pins_t;

  localparam int unsigned PINS_W = $bits(wg_pins_t);
  localparam wg_pins_t PINS_RST = '{sup_ok: 1'b0, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wg_lockout.sv
module wg_lockout #(
  parameter int unsigned LOCK_CYC = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_i,
  output logic ready_o
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LIMIT = LW'(LOCK_CYC);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!sup_i)            cnt_q <= '0;
    else if (cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = sup_i && (cnt_q == LIMIT);

  AST_READY_NEEDS_PRIOR_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(sup_i)); // R2
  AST_NO_READY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sup_i) |-> !ready_o); // R2
endmodule

// File: rtl/wg_pulse_filter.sv
module wg_pulse_filter #(
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,       // drop any run in progress
  input  logic strobe_ni,   // synchronized strobe
  output logic low_ok_o     // strobe qualified low
);
  localparam int unsigned CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (clr_i || strobe_ni)  run_q <= '0;
    else if (run_q != SAT)        run_q <= run_q + 1'b1;
  end

  // fall delayed by the minimum width, rise passed at once
  assign low_ok_o = !strobe_ni && (run_q >= SAT);

  AST_NO_SHORT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((MIN_LOW_CYC > 1) && $rose(low_ok_o)) |-> $past(!strobe_ni)); // R4
  AST_FAST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_ni |-> !low_ok_o); // R6
endmodule

// File: rtl/wguard_top.sv
module wguard_top
  import wg_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 3,
  parameter int unsigned LOCK_CYC    = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic wr_allow_o
);
  wg_pins_t pins_raw, pins_s;
  logic ready;
  logic [1:0] strb_n, strb_ok;  // [0] chip-select, [1] write strobe

  assign pins_raw = '{sup_ok: supply_ok_i, ce_n: ce_ni, we_n: we_ni, oe_n: oe_ni};

  wg_sync #(.W(PINS_W), .RST_VAL(PINS_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  wg_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sup_i  (pins_s.sup_ok),
    .ready_o(ready)
  );

  assign strb_n = {pins_s.we_n, pins_s.ce_n};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    wg_pulse_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (!pins_s.sup_ok),
      .strobe_ni(strb_n[g]),
      .low_ok_o (strb_ok[g])
    );
  end

  assign ce_no      = !(ready && strb_ok[0]);
  assign we_no      = !(ready && strb_ok[1] && pins_s.oe_n);
  assign oe_no      = pins_s.oe_n;
  assign wr_allow_o = ready && pins_s.oe_n && (&strb_ok);

  AST_SUPPLY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_s.sup_ok |-> (ce_no && we_no && !wr_allow_o)); // R1
  AST_OE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (we_no && !wr_allow_o)); // R3
  AST_ALLOW_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_allow_o |-> (!ce_no && !we_no)); // R8
  AST_DROP_ON_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pins_s.sup_ok) |-> !wr_allow_o); // R7
endmodule

// File: tb/wguard_top_tb_top.sv
`timescale 1ns/1ps
module wguard_top_tb_top;
  localparam int MINW = 3;
  localparam int LOCK = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 1'b0, ce = 1'b1, we = 1'b1, oe = 1'b1;
  logic ce_o, we_o, oe_o, alw_o;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R9";
  bit done = 0;

  always #2.5 clk = ~clk;

  wguard_top #(.MIN_LOW_CYC(MINW), .LOCK_CYC(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .ce_ni(ce), .we_ni(we),
    .oe_ni(oe), .ce_no(ce_o), .we_no(we_o), .oe_no(oe_o), .wr_allow_o(alw_o)
  );

  // reference model built from the requirements
  logic [3:0] m1, m2;  // {sup, ce, we, oe}
  int lc, cc, wc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 4'b0111; m2 <= 4'b0111; lc <= 0; cc <= 0; wc <= 0;
    end else begin
      m1 <= {sup, ce, we, oe};
      m2 <= m1;
      lc <= !m2[3] ? 0 : (lc == LOCK ? lc : lc + 1);
      cc <= (!m2[3] || m2[2]) ? 0 : (cc == MINW - 1 ? cc : cc + 1);
      wc <= (!m2[3] || m2[1]) ? 0 : (wc == MINW - 1 ? wc : wc + 1);
    end
  end

  function automatic logic [3:0] expect_out();
    logic rdy, cl, wl;
    rdy = m2[3] && (lc == LOCK);
    cl  = !m2[2] && (cc >= MINW - 1);
    wl  = !m2[1] && (wc >= MINW - 1);
    return {!(rdy && cl), !(rdy && wl && m2[0]), m2[0], rdy && cl && wl && m2[0]};
  endfunction

  task automatic chk(string req, int act, int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one cycle: wait past the edge, compare all outputs with the model
  task automatic tick();
    logic [3:0] e;
    @(negedge clk);
    e = expect_out();
    chk(cur_req, {ce_o, we_o, oe_o, alw_o}, e);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  // low pulse of n cycles on one strobe; count qualified-low cycles
  task automatic pulse(bit on_we, int n, string req);
    int lows = 0;
    if (on_we) we = 1'b0; else ce = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if ((on_we ? we_o : ce_o) == 1'b0) lows++;
    end
    if (on_we) we = 1'b1; else ce = 1'b1;
    for (int i = 0; i < MINW + 6; i++) begin
      tick();
      if ((on_we ? we_o : ce_o) == 1'b0) lows++;
    end
    chk(req, lows, (n >= MINW) ? n - MINW + 1 : 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd7051));
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", {ce_o, we_o, oe_o, alw_o}, 4'b1110);
    rst_n = 1'b1;
    tick();
    chk("R9", {ce_o, we_o, oe_o, alw_o}, 4'b1110);

    // R1: supply low, strobes wiggle
    cur_req = "R1";
    for (int i = 0; i < 60; i++) begin
      ce = 1'($urandom % 2); we = 1'($urandom % 4 != 0); oe = 1'b1;
      tick();
      chk("R1", {ce_o, we_o, alw_o}, 3'b110);
    end

    // R2: lockout length
    cur_req = "R2";
    ce = 1'b0; we = 1'b0; oe = 1'b1;
    repeat (5) tick();
    sup = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!alw_o && n < LOCK + 10);
    chk("R2", n, LOCK + 2);

    // R3: output-enable inhibit
    cur_req = "R3";
    oe = 1'b0;
    tick();
    chk("R3", {we_o, oe_o}, 2'b01);
    tick();
    chk("R3", {we_o, oe_o, alw_o}, 3'b100);
    oe = 1'b1;
    repeat (2) tick();
    chk("R3", {we_o, oe_o, alw_o}, 3'b011);

    // R6: fast release of a held strobe
    cur_req = "R6";
    we = 1'b1;
    tick();
    chk("R6", we_o, 0);
    tick();
    chk("R6", we_o, 1);

    // R4 / R5: pulse widths around the minimum
    cur_req = "R5";
    repeat (4) tick();
    for (int w = 1; w <= MINW + 3; w++) pulse(1'b1, w, (w < MINW) ? "R4" : "R5");
    we = 1'b0; ce = 1'b1;
    repeat (4) tick();
    for (int w = 1; w <= MINW + 3; w++) pulse(1'b0, w, (w < MINW) ? "R4" : "R5");

    // R5: latency of the fall
    ce = 1'b0; we = 1'b1;
    repeat (4) tick();
    we = 1'b0;
    n = 0;
    do begin tick(); n++; end while (we_o && n < 20);
    chk("R5", n, MINW + 1);

    // R7: supply loss mid-strobe
    cur_req = "R7";
    repeat (3) tick();
    sup = 1'b0;
    repeat (2) tick();
    chk("R7", {ce_o, we_o, alw_o}, 3'b110);
    tick();
    sup = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!alw_o && n < LOCK + 10);
    chk("R7", n, LOCK + 2);

    // R8: random mix checked against the model every cycle
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 3 == 0)   we  = ~we;
      if ($urandom % 5 == 0)   ce  = ~ce;
      if ($urandom % 9 == 0)   oe  = ~oe;
      if ($urandom % 250 == 0) sup = ~sup;
      if (!sup && ($urandom % 20 == 0)) sup = 1'b1;
      tick();
      chk("R8", alw_o, (!ce_o && !we_o) ? 1 : 0);
    end
    finish_run();
  end
endmodule